// File: doc/BRIEF.md
# Reference-Locked Divider with Holdover

This block rebuilds a slow reference clock inside a fast system clock domain. A phase counter runs on the system clock and wraps once per nominal reference period. It drives a regenerated square wave and a one-cycle enable pulse. Every reference edge that the block detects forces the counter to the phase that belongs to that edge. Between edges, and after the reference goes quiet, the counter keeps running with the alignment it last received. The regenerated timing therefore carries on through a loss of the reference.

The reference input is asynchronous. It passes through a two-stage synchronizer, and edges are found by comparing the synchronized level with a one-cycle delayed copy. A rising edge sets the phase to zero. A falling edge sets it to the half-period count when both-edge alignment is on, which is the default. A presence flag reports whether edges have arrived recently. It drops after a programmable number of quiet system cycles and comes back on the next edge. Downstream logic can use the square wave as a divided clock or the enable pulse as a clock enable.

Top module: `ref_holdover_div`

## Requirements
- R1: While rst_ni is low, wave_o, tick_o and present_o are all 0.
- R2: After reset release, with no reference edge, the phase is k mod PERIOD_CNT in the k-th cycle after the first rising system clock edge with rst_ni high. The first tick_o therefore comes PERIOD_CNT cycles after release.
- R3: Let c be the system clock edge that first captures a new high level of ref_i. The phase is 0 in the cycle after edge c+2, so tick_o and wave_o are both 1 in that cycle.
- R4: With both-edge alignment on (default), a new low level of ref_i first captured at edge c sets the phase to HALF_CNT in the cycle after edge c+2, so wave_o is 0 and tick_o is 0 in that cycle.
- R5: wave_o is 1 exactly when the phase is below HALF_CNT. tick_o is 1 exactly when the phase is 0, which is one cycle per period.
- R6: With no reference edge the phase advances by one each cycle and wraps from PERIOD_CNT-1 to 0. Output timing continues from the last alignment, with ticks exactly PERIOD_CNT cycles apart.
- R7: present_o becomes 1 in the same cycle that a detected edge realigns the phase. It stays 1 for LOSS_CNT cycles, counting that cycle, and becomes 0 in the next cycle if no further edge arrives.
- R8: A reference whose period is shorter or longer than PERIOD_CNT is followed edge by edge. Every rising edge restarts the phase at 0, even when that cuts short or repeats a period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ref_i | input | 1 | Asynchronous slow reference |
| wave_o | output | 1 | Regenerated square wave, high for the first half of each period |
| tick_o | output | 1 | One-cycle enable at phase zero |
| present_o | output | 1 | Reference edges seen within the last LOSS_CNT cycles |

## Verification
The bench first lets the divider run free from reset, which isolates the start phase and the wrap count from any alignment. It then drives a reference at the nominal period, at periods shorter and longer than nominal, and with an unequal high and low time. These patterns separate rising-edge realignment from falling-edge realignment and show that off-nominal references are followed edge by edge. A long quiet stretch exposes both holdover continuity and the exact cycle in which presence drops. A single-cycle reference pulse then checks that back-to-back rise and fall realignments land on consecutive cycles.

// File: rtl/ref_hold_pkg.sv
package ref_hold_pkg;
  typedef enum logic [1:0] {
    EDGE_NONE = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2
  } edge_e;
endpackage

// File: rtl/ref_sync_edge.sv
module ref_sync_edge
  import ref_hold_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  ref_i,
  output edge_e edge_o
);
  localparam int CHAIN_W = SYNC_STAGES + 1;

  // chain[SYNC_STAGES-1] is the synchronized level, chain[SYNC_STAGES] its delayed copy
  logic [CHAIN_W-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[CHAIN_W-2:0], ref_i};
  end

  logic lvl, lvl_d;
  assign lvl   = chain_q[SYNC_STAGES-1];
  assign lvl_d = chain_q[SYNC_STAGES];

  always_comb begin
    edge_o = EDGE_NONE;
    if (lvl && !lvl_d)      edge_o = EDGE_RISE;
    else if (!lvl && lvl_d) edge_o = EDGE_FALL;
  end
endmodule

// File: rtl/phase_cnt.sv
module phase_cnt
  import ref_hold_pkg::*;
#(
  parameter int PERIOD_CNT = 50,
  parameter int HALF_CNT   = 25,
  parameter bit BOTH_EDGES = 1'b1
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  edge_e edge_i,
  output logic  wave_o,
  output logic  tick_o
);
  localparam int CNT_W = (PERIOD_CNT > 1) ? $clog2(PERIOD_CNT) : 1;
  localparam logic [CNT_W-1:0] LAST_V = CNT_W'(PERIOD_CNT - 1);
  localparam logic [CNT_W-1:0] HALF_V = CNT_W'(HALF_CNT);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic realign_rise, realign_fall;

  assign realign_rise = (edge_i == EDGE_RISE);

  generate
    if (BOTH_EDGES) begin : g_both
      assign realign_fall = (edge_i == EDGE_FALL);
    end else begin : g_rise_only
      assign realign_fall = 1'b0;
    end
  endgenerate

  always_comb begin
    cnt_d = (cnt_q == LAST_V) ? '0 : cnt_q + CNT_W'(1);
    if (realign_rise)      cnt_d = '0;
    else if (realign_fall) cnt_d = HALF_V;
  end

  // outputs registered from cnt_d so they line up with cnt_q, low in reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      wave_o <= 1'b0;
      tick_o <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      wave_o <= (cnt_d < HALF_V);
      tick_o <= (cnt_d == '0);
    end
  end
endmodule

// File: rtl/presence_mon.sv
module presence_mon
  import ref_hold_pkg::*;
#(
  parameter int LOSS_CNT = 200
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  edge_e edge_i,
  output logic  present_o
);
  localparam int TMR_W = (LOSS_CNT > 1) ? $clog2(LOSS_CNT) : 1;
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(LOSS_CNT - 1);

  logic [TMR_W-1:0] tmr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmr_q     <= '0;
      present_o <= 1'b0;
    end else if (edge_i != EDGE_NONE) begin
      tmr_q     <= '0;
      present_o <= 1'b1;
    end else if (tmr_q == TMR_LAST) begin
      present_o <= 1'b0;
    end else begin
      tmr_q <= tmr_q + TMR_W'(1);
    end
  end
endmodule

// File: rtl/ref_holdover_div.sv
module ref_holdover_div
  import ref_hold_pkg::*;
#(
  parameter int PERIOD_CNT  = 50,
  parameter int HALF_CNT    = 25,
  parameter int LOSS_CNT    = 200,
  parameter int SYNC_STAGES = 2,
  parameter bit BOTH_EDGES  = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_i,
  output logic wave_o,
  output logic tick_o,
  output logic present_o
);
  edge_e ref_edge;

  ref_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ref_i  (ref_i),
    .edge_o (ref_edge)
  );

  phase_cnt #(
    .PERIOD_CNT (PERIOD_CNT),
    .HALF_CNT   (HALF_CNT),
    .BOTH_EDGES (BOTH_EDGES)
  ) u_phase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .edge_i (ref_edge),
    .wave_o (wave_o),
    .tick_o (tick_o)
  );

  presence_mon #(.LOSS_CNT(LOSS_CNT)) u_pres (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .edge_i    (ref_edge),
    .present_o (present_o)
  );
endmodule

// File: rtl/ref_holdover_div_chk.sv
module ref_holdover_div_chk
  import ref_hold_pkg::*;
#(
  parameter int PERIOD_CNT = 50,
  parameter int HALF_CNT   = 25,
  parameter int LOSS_CNT   = 200,
  parameter bit BOTH_EDGES = 1'b1
) (
  input logic  clk_i,
  input logic  rst_ni,
  input edge_e edge_i,
  input logic  wave_i,
  input logic  tick_i,
  input logic  present_i
);
  localparam int QMAX = (LOSS_CNT > PERIOD_CNT) ? LOSS_CNT : PERIOD_CNT;
  localparam int Q_W  = $clog2(QMAX + 1);
  localparam int G_W  = $clog2(PERIOD_CNT + 1);

  logic [Q_W-1:0] quiet_q;
  logic [G_W-1:0] gap_q;
  logic           seen_tick_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      quiet_q     <= '0;
      gap_q       <= '0;
      seen_tick_q <= 1'b0;
    end else begin
      if (edge_i != EDGE_NONE)       quiet_q <= '0;
      else if (quiet_q != Q_W'(QMAX)) quiet_q <= quiet_q + Q_W'(1);
      if (tick_i)                           gap_q <= '0;
      else if (gap_q != G_W'(PERIOD_CNT))   gap_q <= gap_q + G_W'(1);
      if (tick_i) seen_tick_q <= 1'b1;
    end
  end

  assert_rise_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_i == EDGE_RISE) |=> (tick_i && wave_i));

  assert_fall_half_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (BOTH_EDGES && edge_i == EDGE_FALL) |=> (!wave_i && !tick_i));

  assert_tick_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> !tick_i);

  assert_tick_in_high_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |-> wave_i);

  assert_hold_period_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && seen_tick_q && quiet_q >= Q_W'(PERIOD_CNT)) |-> (gap_q == G_W'(PERIOD_CNT - 1)));

  assert_present_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_i != EDGE_NONE) |=> present_i);

  assert_present_drop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (quiet_q >= Q_W'(LOSS_CNT)) |-> !present_i);
endmodule

bind ref_holdover_div ref_holdover_div_chk #(
  .PERIOD_CNT (PERIOD_CNT),
  .HALF_CNT   (HALF_CNT),
  .LOSS_CNT   (LOSS_CNT),
  .BOTH_EDGES (BOTH_EDGES)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .edge_i    (ref_edge),
  .wave_i    (wave_o),
  .tick_i    (tick_o),
  .present_i (present_o)
);

// File: tb/ref_holdover_div_tb.sv
module ref_holdover_div_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PER  = 50;
  localparam int HALF = 25;
  localparam int LOSS = 200;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic ref_i = 1'b0;
  logic wave_o, tick_o, present_o;

  ref_holdover_div #(
    .PERIOD_CNT (PER),
    .HALF_CNT   (HALF),
    .LOSS_CNT   (LOSS)
  ) dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .ref_i     (ref_i),
    .wave_o    (wave_o),
    .tick_o    (tick_o),
    .present_o (present_o)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  typedef struct {
    int at;
    bit lvl;
  } ev_t;

  ev_t   evq[$];
  int    cyc = 0;
  int    m_cnt = 0;
  int    m_tmr = 0;
  bit    m_pres = 1'b0;
  int    total = 0;
  int    bad = 0;
  string cur_req = "R2";
  bit    done = 1'b0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s cyc=%0d act=%0d exp=%0d", req, what, cyc, act, exp);
    end
  endtask

  // expected model: phase, presence, driven by events the driver pushed
  always @(posedge clk) begin
    if (rst_ni) begin
      bit hit;
      cyc++;
      hit = 1'b0;
      m_cnt = (m_cnt == PER - 1) ? 0 : m_cnt + 1;
      if (evq.size() > 0 && evq[0].at == cyc) begin
        m_cnt = evq[0].lvl ? 0 : HALF;
        hit = 1'b1;
        void'(evq.pop_front());
      end
      if (hit) begin
        m_pres = 1'b1;
        m_tmr  = 0;
      end else if (m_tmr == LOSS - 1) begin
        m_pres = 1'b0;
      end else begin
        m_tmr++;
      end
    end
  end

  // monitor: compare outputs against the model away from the active edge
  always @(negedge clk) begin
    if (rst_ni && cyc >= 1 && !done) begin
      chk(cur_req, "wave_o", int'(wave_o), int'(m_cnt < HALF));
      chk("R5", "tick_o", int'(tick_o), int'(m_cnt == 0));
      chk("R7", "present_o", int'(present_o), int'(m_pres));
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver: a level change captured at cyc+1 realigns the phase at cyc+3
  task automatic set_ref(input bit v);
    if (v != ref_i) begin
      ev_t e;
      e.at  = cyc + 3;
      e.lvl = v;
      evq.push_back(e);
    end
    ref_i = v;
  endtask

  task automatic run_ref(input int hi, input int lo, input int n);
    for (int i = 0; i < n; i++) begin
      set_ref(1'b1);
      wait_cyc(hi);
      set_ref(1'b0);
      wait_cyc(lo);
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    total++;
    bad++;
    $display("FAIL watchdog expired act=running exp=finished");
    finish_run();
  end

  initial begin
    wait_cyc(4);
    chk("R1", "wave_o in reset", int'(wave_o), 0);
    chk("R1", "tick_o in reset", int'(tick_o), 0);
    chk("R1", "present_o in reset", int'(present_o), 0);
    rst_ni = 1'b1;

    cur_req = "R2";            // free-run from zero, first tick at cycle PER
    wait_cyc(130);

    cur_req = "R3";            // nominal reference at an arbitrary phase
    wait_cyc(7);
    run_ref(25, 25, 6);

    cur_req = "R8";            // short and long periods, uneven duty
    run_ref(20, 27, 5);
    run_ref(30, 23, 5);

    cur_req = "R6";            // loss of reference: holdover and presence drop
    set_ref(1'b0);
    wait_cyc(LOSS + 60);

    cur_req = "R4";            // falling edge sets half-period phase
    run_ref(10, 40, 4);

    cur_req = "R3";            // one-cycle pulse: rise then fall back to back
    set_ref(1'b1);
    wait_cyc(1);
    set_ref(1'b0);
    wait_cyc(80);

    finish_run();
  end
endmodule